// File: doc/BRIEF.md
# Infrared Key Frame Encoder

This block turns one key press into a modulated infrared transmit waveform. A start request captures a 16-bit custom code and an 8-bit data byte. At the next time-base tick the block sends a long leader burst and a leader space, then 32 payload bits, then a closing burst. The payload is the custom code, the data byte and the bitwise inverse of the data byte. Each bit is a one-unit burst followed by a space, and the length of the space carries the bit value.

All timing is counted in base units marked by a one-clock `tick` enable, one unit per tick (about 562.5 us in a real system). Each frame occupies a fixed slot of `FRAME_U` units, counted from the start of the frame. At the end of every slot the block samples `key_held`. If the key is still down it sends a short repeat frame in the next slot. Otherwise it returns to idle. During burst units the output is gated by a free-running square carrier derived from the clock.

Top module: `ir_frame_tx`

## Requirements
- R1: After synchronous reset, `busy` and `tx_out` are low and stay low while no start is given.
- R2: A `start` pulse while `busy` is low raises `busy` on the following cycle. The leader burst occupies the unit that begins at the first tick seen with or after that start.
- R3: A full frame opens with 16 units of burst followed by 8 units of space.
- R4: The 32 payload bits are sent in this order: custom code bit 0 through bit 15, then data bits 0 through 7, then the inverted data bits 0 through 7.
- R5: Every payload bit is a 1-unit burst. The space after it is 1 unit for a 0 and 3 units for a 1.
- R6: One closing burst unit follows the last payload bit. The output then stays quiet until the 192-unit slot ends.
- R7: If `key_held` is high at the tick that ends a slot, a repeat frame starts at that tick. It is 16 units of burst, 4 units of space, one burst unit, and quiet for the rest of its 192-unit slot.
- R8: If `key_held` is low at the tick that ends a slot, `busy` falls at that tick and no further burst is sent. `busy` is high in every unit from the first leader unit to the end of the last slot.
- R9: A `start` pulse while `busy` is high has no effect on the waveform. This holds even when it comes with a different custom code and data byte.
- R10: During a burst unit, `tx_out` is a square wave that is high for `CAR_HALF` clocks and low for `CAR_HALF` clocks. Outside burst units, `tx_out` is low.
- R11: The burst or space state changes only on the clock after a `tick`. Without ticks the waveform stage is held, and it resumes unchanged once ticks return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock pulse marking each base time unit |
| start | input | 1 | Request to send a frame for a new key press |
| key_held | input | 1 | High while the key remains pressed |
| custom_code | input | 16 | Custom (address) code captured at start |
| data_byte | input | 8 | Data byte captured at start |
| tx_out | output | 1 | Carrier-gated transmit output, active high |
| busy | output | 1 | High from start until the last slot ends |

## Verification
Each segment is counted down in units. An off-by-one in a segment counter therefore moves every later edge of the frame by a whole unit. A wrong shift or bit index flips the space length of a specific payload bit inside the first frame. Both faults show up in the per-unit envelope the bench rebuilds from `tx_out`. The slot timer and key sampling only reveal a fault at the end of a 192-unit slot. They show as a repeat frame at the wrong spacing, or as `busy` falling one unit early or late. The bench therefore runs every press to completion and checks the unit in which `busy` drops.

// File: rtl/ir_tx_pkg.sv
// Package: shared state encoding for the infrared frame encoder.
// Assumes nothing beyond the users of it importing the enum.
package ir_tx_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LDR_MARK,
        S_LDR_SPACE,
        S_BIT_MARK,
        S_BIT_SPACE,
        S_STOP,
        S_GAP,
        S_REP_MARK,
        S_REP_SPACE,
        S_REP_STOP
    } seq_state_t;

    // True for every stage that drives carrier onto the output.
    function automatic logic is_mark(seq_state_t s);
        return (s == S_LDR_MARK) || (s == S_BIT_MARK) || (s == S_STOP) ||
               (s == S_REP_MARK) || (s == S_REP_STOP);
    endfunction

endpackage

// File: rtl/ir_carrier_gen.sv
// Carrier generator: free-running square wave, HALF clocks high then HALF low.
// Assumes HALF >= 1; phase starts low after reset.
module ir_carrier_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    // Count clocks in the current half period and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_slot_timer.sv
// Slot timer: counts time units since the last frame start and flags the
// last unit of the slot. Assumes restart only arrives together with a tick.
module ir_slot_timer #(
    parameter int FRAME_U = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic slot_end
);
    localparam int TW = $clog2(FRAME_U);

    logic [TW-1:0] cnt;

    // Restart at a frame start, otherwise advance once per tick up to the last unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick && (cnt != TW'(FRAME_U - 1))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign slot_end = (cnt == TW'(FRAME_U - 1));
endmodule

// File: rtl/ir_frame_seq.sv
// Frame sequencer: walks the leader, payload bits, closing burst, slot gap
// and repeat frames, one step per tick. Assumes FRAME_U is longer than the
// longest full frame so that the gap stage is always reached.
module ir_frame_seq
    import ir_tx_pkg::*;
#(
    parameter int CUSTOM_W    = 16,
    parameter int DATA_W      = 8,
    parameter int LDR_MARK_U  = 16,
    parameter int LDR_SPACE_U = 8,
    parameter int REP_SPACE_U = 4,
    parameter int ONE_SPACE_U = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic                key_held,
    input  logic [CUSTOM_W-1:0] custom_code,
    input  logic [DATA_W-1:0]   data_byte,
    input  logic                slot_end,
    output logic                restart,
    output logic                mark,
    output logic                busy
);
    localparam int PAY_W   = CUSTOM_W + 2 * DATA_W;
    localparam int BW      = $clog2(PAY_W);
    localparam int MAX_A   = (LDR_MARK_U > LDR_SPACE_U) ? LDR_MARK_U : LDR_SPACE_U;
    localparam int MAX_B   = (REP_SPACE_U > ONE_SPACE_U) ? REP_SPACE_U : ONE_SPACE_U;
    localparam int SEG_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int SW      = $clog2(SEG_MAX + 1);

    seq_state_t       state;
    logic [SW-1:0]    seg_left;
    logic [BW-1:0]    bit_idx;
    logic [PAY_W-1:0] shreg;
    logic             pending;
    logic [PAY_W-1:0] payload;
    logic             go_idle;
    logic             go_rep;

    // Payload in transmit order: LSB of the shift register goes first.
    assign payload = {~data_byte, data_byte, custom_code};
    assign go_idle = tick && (state == S_IDLE) && (pending || start);
    assign go_rep  = tick && (state == S_GAP) && slot_end && key_held;
    assign restart = go_idle || go_rep;
    assign mark    = is_mark(state);
    assign busy    = pending || (state != S_IDLE);

    // Stage machine: capture a request, then advance the segment count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            seg_left <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            pending  <= 1'b0;
        end else begin
            if ((state == S_IDLE) && !pending && start && !tick) begin
                pending <= 1'b1;
                shreg   <= payload;
            end
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (pending || start) begin
                            state    <= S_LDR_MARK;
                            seg_left <= SW'(LDR_MARK_U - 1);
                            pending  <= 1'b0;
                            if (!pending) shreg <= payload;
                        end
                    end
                    S_GAP: begin
                        if (slot_end) begin
                            if (key_held) begin
                                state    <= S_REP_MARK;
                                seg_left <= SW'(LDR_MARK_U - 1);
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: begin
                        if (seg_left != '0) begin
                            seg_left <= seg_left - 1'b1;
                        end else begin
                            case (state)
                                S_LDR_MARK: begin
                                    state    <= S_LDR_SPACE;
                                    seg_left <= SW'(LDR_SPACE_U - 1);
                                end
                                S_LDR_SPACE: begin
                                    state    <= S_BIT_MARK;
                                    seg_left <= '0;
                                    bit_idx  <= '0;
                                end
                                S_BIT_MARK: begin
                                    state    <= S_BIT_SPACE;
                                    seg_left <= shreg[0] ? SW'(ONE_SPACE_U - 1) : '0;
                                end
                                S_BIT_SPACE: begin
                                    shreg    <= shreg >> 1;
                                    seg_left <= '0;
                                    if (bit_idx == BW'(PAY_W - 1)) begin
                                        state <= S_STOP;
                                    end else begin
                                        state   <= S_BIT_MARK;
                                        bit_idx <= bit_idx + 1'b1;
                                    end
                                end
                                S_REP_MARK: begin
                                    state    <= S_REP_SPACE;
                                    seg_left <= SW'(REP_SPACE_U - 1);
                                end
                                S_REP_SPACE: begin
                                    state    <= S_REP_STOP;
                                    seg_left <= '0;
                                end
                                default: begin
                                    state <= S_GAP;
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ir_frame_tx.sv
// Top: infrared key frame encoder. Joins the sequencer, the slot timer and the
// carrier generator, and gates the carrier with the burst envelope.
// Assumes tick is a single-clock pulse no more often than every clock.
module ir_frame_tx #(
    parameter int CUSTOM_W    = 16,
    parameter int DATA_W      = 8,
    parameter int LDR_MARK_U  = 16,
    parameter int LDR_SPACE_U = 8,
    parameter int REP_SPACE_U = 4,
    parameter int ONE_SPACE_U = 3,
    parameter int FRAME_U     = 192,
    parameter int CAR_HALF    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic                key_held,
    input  logic [CUSTOM_W-1:0] custom_code,
    input  logic [DATA_W-1:0]   data_byte,
    output logic                tx_out,
    output logic                busy
);
    logic restart_w;
    logic slot_end_w;
    logic mark_w;
    logic phase_w;

    ir_frame_seq #(
        .CUSTOM_W    (CUSTOM_W),
        .DATA_W      (DATA_W),
        .LDR_MARK_U  (LDR_MARK_U),
        .LDR_SPACE_U (LDR_SPACE_U),
        .REP_SPACE_U (REP_SPACE_U),
        .ONE_SPACE_U (ONE_SPACE_U)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start       (start),
        .key_held    (key_held),
        .custom_code (custom_code),
        .data_byte   (data_byte),
        .slot_end    (slot_end_w),
        .restart     (restart_w),
        .mark        (mark_w),
        .busy        (busy)
    );

    ir_slot_timer #(.FRAME_U(FRAME_U)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart_w),
        .slot_end (slot_end_w)
    );

    ir_carrier_gen #(.HALF(CAR_HALF)) u_car (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase_w)
    );

    // Output gate: carrier only during burst units.
    assign tx_out = mark_w & phase_w;
endmodule

// File: rtl/ir_frame_chk.sv
// Checker: temporal properties of the frame encoder, bound to the top.
module ir_frame_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic start,
    input logic busy,
    input logic tx_out,
    input logic mark
);
    // R10: output is silent whenever the block is idle.
    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_out);

    // R10: carrier reaches the output only inside a burst unit.
    p_tx_in_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out |-> mark);

    // R2: an accepted start makes the block busy on the next cycle.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: busy is released only by a tick at the end of a slot.
    p_busy_drop_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

    // R11: the burst envelope moves only on the clock after a tick.
    p_mark_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mark) |-> $past(tick));
endmodule

bind ir_frame_tx ir_frame_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .start  (start),
    .busy   (busy),
    .tx_out (tx_out),
    .mark   (mark_w)
);

// File: tb/tb_ir_frame_tx.sv
// Bench: rebuilds the per-unit envelope from tx_out and compares it with a
// frame computed from the requirements, over a sweep of codes and modes.
module tb_ir_frame_tx;
    localparam int TICK_DIV = 8;
    localparam int SLOT     = 192;
    localparam int MAXU     = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic        key_held = 1'b0;
    logic [15:0] custom_code = '0;
    logic [7:0]  data_byte = '0;
    logic        tx_out;
    logic        busy;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    int hi_u [0:MAXU-1];
    bit busy_u [0:MAXU-1];
    int n_units = 0;
    int hi_acc = 0;
    bit take_bz = 1'b1;
    bit bz_first = 1'b0;
    int gcnt = 0;
    int stall_clks = 0;

    bit exp_u [0:MAXU-1];
    int exp_t [0:MAXU-1];
    int exp_n = 0;

    ir_frame_tx #(.CAR_HALF(1)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start       (start),
        .key_held    (key_held),
        .custom_code (custom_code),
        .data_byte   (data_byte),
        .tx_out      (tx_out),
        .busy        (busy)
    );

    always #4 clk = ~clk;

    // Window recorder and tick generator, both on the falling edge.
    always @(negedge clk) begin
        if (tick) begin
            if (n_units < MAXU) begin
                hi_u[n_units]   = hi_acc;
                busy_u[n_units] = bz_first;
                n_units++;
            end
            hi_acc  = 0;
            take_bz = 1'b1;
        end
        if (take_bz) begin
            bz_first = busy;
            take_bz  = 1'b0;
        end
        hi_acc += int'(tx_out);
        if (stall_clks > 0) begin
            stall_clks--;
            tick = 1'b0;
        end else begin
            gcnt++;
            tick = (gcnt == TICK_DIV);
            if (gcnt == TICK_DIV) gcnt = 0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic string tag_name(input int t);
        case (t)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic wait_clk();
        @(negedge clk);
        #1;
    endtask

    task automatic push(input bit v, input int n, input int t);
        for (int k = 0; k < n; k++) begin
            exp_u[exp_n] = v;
            exp_t[exp_n] = t;
            exp_n++;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected envelope of one press from the requirements.
    task automatic build(input logic [15:0] cu, input logic [7:0] d, input int reps);
        logic [31:0] pay;
        int base;
        pay   = {~d, d, cu};
        exp_n = 0;
        push(1'b1, 16, 3);                         // R3 leader burst
        push(1'b0, 8, 3);                          // R3 leader space
        for (int i = 0; i < 32; i++) begin
            push(1'b1, 1, 5);                      // R5 bit burst
            push(1'b0, pay[i] ? 3 : 1, 4);         // R4 order carried by space length
        end
        push(1'b1, 1, 6);                          // R6 closing burst
        push(1'b0, SLOT - exp_n, 6);
        for (int r = 0; r < reps; r++) begin
            base = exp_n;
            push(1'b1, 16, 7);                     // R7 repeat frame
            push(1'b0, 4, 7);
            push(1'b1, 1, 7);
            push(1'b0, base + SLOT - exp_n, 7);
        end
    endtask

    // Compare the recorded windows with the expected envelope; returns errors.
    task automatic check_frame(input int s, input bit chk_car, input int reps, output int errs);
        int f;
        int err [0:15];
        int fa [0:15];
        int fe [0:15];
        bit g;
        errs = 0;
        f = -1;
        for (int t = 0; t < 16; t++) begin
            err[t] = 0; fa[t] = 0; fe[t] = 0;
        end
        for (int i = 0; i < n_units; i++)
            if (f < 0 && hi_u[i] > 0) f = i;
        check(f == s + 1, "R2 first leader unit", f, s + 1);
        if (f < 0) f = 0;
        for (int i = 0; i < exp_n; i++) begin
            g = (f + i < n_units) ? (hi_u[f + i] > 0) : 1'b0;
            if (g != exp_u[i]) begin
                if (err[exp_t[i]] == 0) begin fa[exp_t[i]] = int'(g); fe[exp_t[i]] = int'(exp_u[i]); end
                err[exp_t[i]]++;
            end
            if (!((f + i < n_units) && busy_u[f + i])) begin
                if (err[8] == 0) begin fa[8] = 0; fe[8] = 1; end
                err[8]++;
            end
            if (chk_car && exp_u[i] && (f + i < n_units) && (hi_u[f + i] != TICK_DIV / 2)) begin
                if (err[10] == 0) begin fa[10] = hi_u[f + i]; fe[10] = TICK_DIV / 2; end
                err[10]++;
            end
        end
        if (!((f + exp_n < n_units) && !busy_u[f + exp_n] && hi_u[f + exp_n] == 0)) begin
            if (err[8] == 0) begin fa[8] = 1; fe[8] = 0; end
            err[8]++;
        end
        for (int t = 3; t <= 10; t++) begin
            if ((t == 7 && reps == 0) || t == 9 || (t == 10 && !chk_car)) continue;
            total++;
            errs += err[t];
            if (err[t] != 0) begin
                bad++;
                $display("FAIL %s: %0d unit mismatches, first actual=%0d expected=%0d",
                         tag_name(t), err[t], fa[t], fe[t]);
            end
        end
    endtask

    // One key press: start, optional disturbances, key release, completion.
    task automatic run_press(input logic [15:0] cu, input logic [7:0] d, input int reps,
                             input bit chk_car, input bit inject, input bit stall,
                             output int errs);
        int s;
        int n;
        wait_clk();
        n_units     = 0;
        custom_code = cu;
        data_byte   = d;
        key_held    = (reps > 0);
        start       = 1'b1;
        s           = n_units;
        wait_clk();
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (inject) begin
            repeat (40 * TICK_DIV) wait_clk();
            custom_code = ~cu;
            data_byte   = d ^ 8'h5A;
            start       = 1'b1;                    // R9 request while busy
            wait_clk();
            start = 1'b0;
        end
        if (stall) begin
            repeat (30 * TICK_DIV + 3) wait_clk();
            stall_clks = 77;                       // R11 hold ticks off mid-frame
        end
        if (reps > 0) begin
            n = 0;
            while (n_units < s + 1 + SLOT * reps + 10 && n < 100000) begin wait_clk(); n++; end
            key_held = 1'b0;
        end
        n = 0;
        while (busy && n < 100000) begin wait_clk(); n++; end
        repeat (3 * TICK_DIV) wait_clk();
        build(cu, d, reps);
        check_frame(s, chk_car, reps, errs);
    endtask

    initial begin
        int errs;
        logic [15:0] cus [0:5];
        logic [7:0]  dats [0:5];
        cus[0] = 16'h0000; dats[0] = 8'h00;
        cus[1] = 16'hFFFF; dats[1] = 8'hFF;
        cus[2] = 16'h1234; dats[2] = 8'hA5;
        cus[3] = 16'h8001; dats[3] = 8'h3C;
        cus[4] = 16'h00FF; dats[4] = 8'h01;
        cus[5] = 16'hC35A; dats[5] = 8'h80;

        repeat (5) wait_clk();
        check(busy == 1'b0 && tx_out == 1'b0, "R1 outputs in reset", int'(busy) + int'(tx_out), 0);
        rst_n = 1'b1;
        begin
            int hits = 0;
            for (int i = 0; i < 4 * TICK_DIV; i++) begin
                wait_clk();
                hits += int'(busy) + int'(tx_out);
            end
            check(hits == 0, "R1 idle after reset", hits, 0);
        end

        // Sweep of code patterns, single press (R3..R6, R8, R10).
        for (int k = 0; k < 6; k++) run_press(cus[k], dats[k], 0, 1'b1, 1'b0, 1'b0, errs);

        // Held key: two repeat frames (R7, R8).
        run_press(16'h6E21, 8'h47, 2, 1'b1, 1'b0, 1'b0, errs);
        // Held key: one repeat frame.
        run_press(16'hFFFE, 8'h7F, 1, 1'b1, 1'b0, 1'b0, errs);

        // Start while busy must not disturb the frame (R9).
        run_press(16'hBEEF, 8'h12, 0, 1'b1, 1'b1, 1'b0, errs);
        check(errs == 0, "R9 frame unchanged by busy start", errs, 0);

        // Tick stall mid-frame: envelope resumes unchanged (R11).
        run_press(16'h0F0F, 8'hC3, 0, 1'b0, 1'b0, 1'b1, errs);
        check(errs == 0, "R11 frame intact across tick stall", errs, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule